// File: doc/BRIEF.md
# Root Port Error Collector

This block gathers error reports that arrive at a PCIe root port and turns them into the root error status state and an interrupt. Each report carries a severity (correctable, non-fatal or fatal) and a 16-bit requester identity. The block keeps a set of received flags, remembers which requester sent the first correctable and the first uncorrectable report, and flags repeats and a leading fatal error.

Software reaches three registers through a simple word interface: an enable register holding one enable per severity, the status register whose flags clear on writing ones, and a read-only source register with the two captured identities. The interrupt goes out as a one-cycle MSI-X pulse, else a one-cycle MSI pulse, else a legacy level, depending on two mode inputs. The message number that travels with the interrupt is a hardware-owned field in the top bits of the status word.

Top module: `rp_err_collector`

## Requirements
- R1: A correctable report captures its requester into source bits [15:0] when status bit 0 (correctable received) is clear, and sets status bit 1 (multiple correctable) when bit 0 was already set; bit 0 is set in both cases.
- R2: A non-fatal report sets status bit 5; a fatal report sets status bit 6 and also sets status bit 4 (first fatal) only when status bit 2 (uncorrectable received) was clear before it.
- R3: A non-fatal or fatal report captures its requester into source bits [31:16] when status bit 2 is clear, and sets status bit 3 (multiple uncorrectable) when bit 2 was already set; bit 2 is set in both cases.
- R4: A report (severity code 1 correctable, 2 non-fatal, 3 fatal) interrupts only when the enable for its severity is set (enable bit 0 correctable, bit 1 non-fatal, bit 2 fatal) and the status held before it had no received flag (bits 0, 5, 6) whose enable was already set.
- R5: With msix_en high an interrupt is a one-cycle msix_pulse; else with msi_en high it is a one-cycle msi_pulse; the two never assert together, and irq_vector always shows the message number held in status bits [31:27].
- R6: With both mode inputs low, a write to the enable register sets intx_level to whether any enabled received flag is present; an interrupting report raises intx_level; clearing status alone leaves intx_level unchanged.
- R7: In a message mode, a write to the enable register fires one pulse only when the new value enables a received flag that the previous value did not.
- R8: Reset clears the enable register, the flags and the source register; writing ones to the status register clears only the flags named in bits [6:0], never the message number nor the captured sources.
- R9: Register addresses are 0 for enables (bits [2:0]), 1 for status (flags [6:0], message number [31:27]) and 2 for sources; the message number follows msg_num one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | An error report is present this cycle |
| msg_sev | input | 2 | Report severity: 1 correctable, 2 non-fatal, 3 fatal |
| msg_src | input | 16 | Requester identity of the report |
| msg_num | input | 5 | Interrupt message number assigned by the interrupt setup |
| msix_en | input | 1 | MSI-X delivery is enabled |
| msi_en | input | 1 | MSI delivery is enabled |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| msix_pulse | output | 1 | One-cycle MSI-X interrupt request |
| msi_pulse | output | 1 | One-cycle MSI interrupt request |
| irq_vector | output | 5 | Message number sent with a pulse |
| intx_level | output | 1 | Legacy interrupt level |

## Verification
The assertions assume that a report and a status clear landing in the same cycle resolve clear-first, and several are written only for cycles without such a clear; they also assume a severity code of 0 with msg_valid high is a non-report. The stimulus never issues a report and a register write in the same cycle, always uses severity codes 1 to 3, and changes the mode inputs only right after a reset, so every check sees the effect of a single cause.

// File: rtl/rp_err_pkg.sv
package rp_err_pkg;

  localparam int FLAG_W = 7;
  localparam int EN_W   = 3;

  // status flag positions
  localparam int F_COR   = 0;
  localparam int F_MCOR  = 1;
  localparam int F_UNC   = 2;
  localparam int F_MUNC  = 3;
  localparam int F_FIRST = 4;
  localparam int F_NF    = 5;
  localparam int F_FAT   = 6;

  typedef enum logic [1:0] {
    SEV_NONE     = 2'd0,
    SEV_COR      = 2'd1,
    SEV_NONFATAL = 2'd2,
    SEV_FATAL    = 2'd3
  } sev_e;

  // enable bit selected by a severity
  function automatic logic [EN_W-1:0] sev_enable(sev_e s);
    case (s)
      SEV_COR:      return 3'b001;
      SEV_NONFATAL: return 3'b010;
      SEV_FATAL:    return 3'b100;
      default:      return 3'b000;
    endcase
  endfunction

  // received flags expressed as the enables they map onto
  function automatic logic [EN_W-1:0] status_enable(logic [FLAG_W-1:0] f);
    return {f[F_FAT], f[F_NF], f[F_COR]};
  endfunction

  // flag update for one report
  function automatic logic [FLAG_W-1:0] merge_flags(logic [FLAG_W-1:0] f, sev_e s);
    logic [FLAG_W-1:0] r;
    r = f;
    case (s)
      SEV_COR: begin
        r[F_MCOR] = r[F_MCOR] | f[F_COR];
        r[F_COR]  = 1'b1;
      end
      SEV_NONFATAL: r[F_NF] = 1'b1;
      SEV_FATAL: begin
        r[F_FIRST] = r[F_FIRST] | ~f[F_UNC];
        r[F_FAT]   = 1'b1;
      end
      default: ;
    endcase
    if (s == SEV_NONFATAL || s == SEV_FATAL) begin
      r[F_MUNC] = r[F_MUNC] | f[F_UNC];
      r[F_UNC]  = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/rp_err_status.sv
module rp_err_status
  import rp_err_pkg::*;
#(
  parameter int SRC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_valid,
  input  sev_e              msg_sev,
  input  logic [SRC_W-1:0]  msg_src,
  input  logic              clr_valid,
  input  logic [FLAG_W-1:0] clr_mask,
  output logic [FLAG_W-1:0] flags_q,
  output logic [SRC_W-1:0]  src_cor_q,
  output logic [SRC_W-1:0]  src_unc_q
);

  logic              msg_take;
  logic              is_unc;
  logic [FLAG_W-1:0] flags_base;
  logic [FLAG_W-1:0] flags_d;
  logic [SRC_W-1:0]  src_cor_d;
  logic [SRC_W-1:0]  src_unc_d;

  assign msg_take = msg_valid && (msg_sev != SEV_NONE);
  assign is_unc   = (msg_sev == SEV_NONFATAL) || (msg_sev == SEV_FATAL);

  // software clear resolves before the report of the same cycle
  always_comb begin
    flags_base = flags_q & ~(clr_valid ? clr_mask : '0);
    flags_d    = flags_base;
    src_cor_d  = src_cor_q;
    src_unc_d  = src_unc_q;
    if (msg_take) begin
      flags_d = merge_flags(flags_base, msg_sev);
      if (msg_sev == SEV_COR && !flags_base[F_COR]) src_cor_d = msg_src;
      if (is_unc && !flags_base[F_UNC])            src_unc_d = msg_src;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q   <= '0;
      src_cor_q <= '0;
      src_unc_q <= '0;
    end else begin
      flags_q   <= flags_d;
      src_cor_q <= src_cor_d;
      src_unc_q <= src_unc_d;
    end
  end

  assert_multi_cor_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == SEV_COR && flags_q[F_COR] && !clr_valid) |=> flags_q[F_MCOR]);

  assert_cor_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == SEV_COR && !flags_q[F_COR] && !clr_valid)
      |=> src_cor_q == $past(msg_src));

  assert_first_fatal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == SEV_FATAL && !flags_q[F_UNC] && !clr_valid)
      |=> flags_q[F_FIRST] && flags_q[F_FAT]);

  assert_unc_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && is_unc && !flags_q[F_UNC] && !clr_valid)
      |=> src_unc_q == $past(msg_src) && flags_q[F_UNC]);

  assert_src_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |=> $stable(src_cor_q) && $stable(src_unc_q));

endmodule

// File: rtl/rp_err_notify.sv
module rp_err_notify
  import rp_err_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_valid,
  input  sev_e              msg_sev,
  input  logic [FLAG_W-1:0] flags_q,
  input  logic [EN_W-1:0]   cmd_q,
  input  logic              cmd_wr,
  input  logic [EN_W-1:0]   cmd_wdata,
  input  logic              msix_en,
  input  logic              msi_en,
  output logic              msix_pulse_q,
  output logic              msi_pulse_q,
  output logic              intx_q
);

  logic [EN_W-1:0] held_en;
  logic            msg_fire;
  logic            wr_fire;
  logic            msg_mode;

  assign held_en  = status_enable(flags_q);
  assign msg_mode = msix_en || msi_en;

  // report: its severity is enabled and nothing enabled was already pending
  assign msg_fire = msg_valid && (msg_sev != SEV_NONE)
                 && |(cmd_q & sev_enable(msg_sev))
                 && !(|(cmd_q & held_en));

  // enable write: a pending flag becomes enabled for the first time
  assign wr_fire = cmd_wr && |(cmd_wdata & held_en) && !(|(cmd_q & held_en));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msix_pulse_q <= 1'b0;
      msi_pulse_q  <= 1'b0;
      intx_q       <= 1'b0;
    end else begin
      msix_pulse_q <= msix_en && (msg_fire || wr_fire);
      msi_pulse_q  <= !msix_en && msi_en && (msg_fire || wr_fire);
      if (msg_mode)
        intx_q <= 1'b0;
      else
        intx_q <= (cmd_wr ? |(cmd_wdata & held_en) : intx_q) | msg_fire;
    end
  end

  assert_one_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({msix_pulse_q, msi_pulse_q}));

  assert_msix_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    msi_pulse_q |-> !$past(msix_en));

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (msix_pulse_q || msi_pulse_q) |=> !(msix_pulse_q || msi_pulse_q));

  assert_no_repeat_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !cmd_wr && |(cmd_q & held_en)) |=> !msix_pulse_q && !msi_pulse_q);

  assert_intx_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_mode |=> !intx_q);

endmodule

// File: rtl/rp_err_collector.sv
module rp_err_collector
  import rp_err_pkg::*;
#(
  parameter int SRC_W  = 16,
  parameter int VEC_W  = 5,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_valid,
  input  logic [1:0]        msg_sev,
  input  logic [SRC_W-1:0]  msg_src,
  input  logic [VEC_W-1:0]  msg_num,
  input  logic              msix_en,
  input  logic              msi_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              msix_pulse,
  output logic              msi_pulse,
  output logic [VEC_W-1:0]  irq_vector,
  output logic              intx_level
);

  localparam int STAT_PAD = DATA_W - VEC_W - FLAG_W;
  localparam int CMD_PAD  = DATA_W - EN_W;
  localparam logic [ADDR_W-1:0] A_CMD  = 0;
  localparam logic [ADDR_W-1:0] A_STAT = 1;
  localparam logic [ADDR_W-1:0] A_SRC  = 2;

  sev_e              sev;
  logic [EN_W-1:0]   cmd_q;
  logic [VEC_W-1:0]  vec_q;
  logic              cmd_wr;
  logic              stat_wr;
  logic [FLAG_W-1:0] flags_q;
  logic [SRC_W-1:0]  src_cor_q;
  logic [SRC_W-1:0]  src_unc_q;

  assign sev     = sev_e'(msg_sev);
  assign cmd_wr  = reg_wr && (reg_addr == A_CMD);
  assign stat_wr = reg_wr && (reg_addr == A_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      vec_q <= '0;
    end else begin
      vec_q <= msg_num;
      if (cmd_wr) cmd_q <= reg_wdata[EN_W-1:0];
    end
  end

  rp_err_status #(.SRC_W(SRC_W)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_valid (msg_valid),
    .msg_sev   (sev),
    .msg_src   (msg_src),
    .clr_valid (stat_wr),
    .clr_mask  (reg_wdata[FLAG_W-1:0]),
    .flags_q   (flags_q),
    .src_cor_q (src_cor_q),
    .src_unc_q (src_unc_q)
  );

  rp_err_notify u_notify (
    .clk          (clk),
    .rst_n        (rst_n),
    .msg_valid    (msg_valid),
    .msg_sev      (sev),
    .flags_q      (flags_q),
    .cmd_q        (cmd_q),
    .cmd_wr       (cmd_wr),
    .cmd_wdata    (reg_wdata[EN_W-1:0]),
    .msix_en      (msix_en),
    .msi_en       (msi_en),
    .msix_pulse_q (msix_pulse),
    .msi_pulse_q  (msi_pulse),
    .intx_q       (intx_level)
  );

  assign irq_vector = vec_q;

  always_comb begin
    case (reg_addr)
      A_CMD:   reg_rdata = {{CMD_PAD{1'b0}}, cmd_q};
      A_STAT:  reg_rdata = {vec_q, {STAT_PAD{1'b0}}, flags_q};
      A_SRC:   reg_rdata = {src_unc_q, src_cor_q};
      default: reg_rdata = '0;
    endcase
  end

  assert_vec_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> irq_vector == $past(msg_num));

  assert_cmd_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> cmd_q == $past(reg_wdata[EN_W-1:0]));

endmodule

// File: tb/rp_err_collector_bench.sv
module rp_err_collector_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 1'b0;
  logic [1:0]  msg_sev = 2'd0;
  logic [15:0] msg_src = 16'd0;
  logic [4:0]  msg_num = 5'd0;
  logic        msix_en = 1'b0;
  logic        msi_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        msix_pulse;
  logic        msi_pulse;
  logic [4:0]  irq_vector;
  logic        intx_level;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rp_err_collector u_rp_err_collector (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_sev(msg_sev),
    .msg_src(msg_src), .msg_num(msg_num), .msix_en(msix_en), .msi_en(msi_en),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .msix_pulse(msix_pulse), .msi_pulse(msi_pulse),
    .irq_vector(irq_vector), .intx_level(intx_level)
  );

  // table entry: op(2) sev(2) arg(16) exp_flags(7) exp_src(32) exp_msi_pulse(1)
  // op 0 = report with sev/src=arg, op 1 = status clear with mask=arg
  localparam int NV = 8;
  localparam logic [59:0] TBL [NV] = '{
    {2'd0, 2'd1, 16'h0011, 7'h01, 32'h0000_0011, 1'b1},
    {2'd0, 2'd1, 16'h0022, 7'h03, 32'h0000_0011, 1'b0},
    {2'd0, 2'd2, 16'h0033, 7'h27, 32'h0033_0011, 1'b0},
    {2'd0, 2'd3, 16'h0044, 7'h6F, 32'h0033_0011, 1'b0},
    {2'd1, 2'd0, 16'h007F, 7'h00, 32'h0033_0011, 1'b0},
    {2'd0, 2'd3, 16'h0055, 7'h54, 32'h0055_0011, 1'b1},
    {2'd0, 2'd2, 16'h0066, 7'h7C, 32'h0055_0011, 1'b0},
    {2'd0, 2'd1, 16'h0077, 7'h7D, 32'h0055_0077, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    msg_valid = 1'b0;
    reg_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // after return the edge that took the action has passed
  task automatic send(input logic [1:0] s, input logic [15:0] src);
    @(negedge clk);
    msg_valid = 1'b1; msg_sev = s; msg_src = src;
    @(negedge clk);
    msg_valid = 1'b0; msg_sev = 2'd0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin : watchdog
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    do_reset();
    #1;
    // R8: reset state
    rd(2'd0, d); chk("R8 enables after reset", d, 32'd0);
    rd(2'd1, d); chk("R8 flags after reset", {25'd0, d[6:0]}, 32'd0);
    rd(2'd2, d); chk("R8 sources after reset", d, 32'd0);
    chk("R8 outputs after reset", {29'd0, msix_pulse, msi_pulse, intx_level}, 32'd0);

    // table walk: MSI mode, all enables on, message number 9
    msi_en = 1'b1; msg_num = 5'd9;
    wr(2'd0, 32'h7);
    for (int i = 0; i < NV; i++) begin
      logic [59:0] e;
      e = TBL[i];
      if (e[59:58] == 2'd0) send(e[57:56], e[55:40]);
      else                  wr(2'd1, {16'd0, e[55:40]});
      chk($sformatf("R4 table %0d msi pulse", i), {31'd0, msi_pulse}, {31'd0, e[0]});
      rd(2'd1, d);
      chk($sformatf("R1 R2 R3 table %0d flags", i), {25'd0, d[6:0]}, {25'd0, e[39:33]});
      chk($sformatf("R9 table %0d message number", i), {27'd0, d[31:27]}, 32'd9);
      rd(2'd2, d);
      chk($sformatf("R1 R3 table %0d sources", i), d, e[32:1]);
    end

    // R4 / R7: disabled report, then enable write in MSI mode
    do_reset();
    msi_en = 1'b1; msix_en = 1'b0;
    send(2'd1, 16'h0101);
    chk("R4 disabled severity no pulse", {31'd0, msi_pulse}, 32'd0);
    wr(2'd0, 32'h1);
    chk("R7 newly enabled write pulses", {31'd0, msi_pulse}, 32'd1);
    @(negedge clk);
    chk("R5 pulse lasts one cycle", {31'd0, msi_pulse}, 32'd0);
    wr(2'd0, 32'h1);
    chk("R7 same enable write no pulse", {31'd0, msi_pulse}, 32'd0);

    // R6: legacy level follows enable writes
    do_reset();
    msi_en = 1'b0; msix_en = 1'b0;
    send(2'd2, 16'h0202);
    chk("R6 disabled report keeps level low", {31'd0, intx_level}, 32'd0);
    wr(2'd0, 32'h2);
    chk("R6 enable write raises level", {31'd0, intx_level}, 32'd1);
    wr(2'd0, 32'h1);
    chk("R6 enable write drops level", {31'd0, intx_level}, 32'd0);
    wr(2'd0, 32'h2);
    wr(2'd1, 32'h7F);
    chk("R6 status clear keeps level", {31'd0, intx_level}, 32'd1);
    wr(2'd0, 32'h2);
    chk("R6 rewrite with clear status drops level", {31'd0, intx_level}, 32'd0);

    do_reset();
    wr(2'd0, 32'h4);
    send(2'd3, 16'h0303);
    chk("R6 enabled report raises level", {31'd0, intx_level}, 32'd1);

    // R5: MSI-X wins over MSI, vector from message number
    do_reset();
    msix_en = 1'b1; msi_en = 1'b1; msg_num = 5'd21;
    wr(2'd0, 32'h4);
    send(2'd3, 16'h0404);
    chk("R5 msix pulse", {31'd0, msix_pulse}, 32'd1);
    chk("R5 msi quiet under msix", {31'd0, msi_pulse}, 32'd0);
    chk("R5 vector value", {27'd0, irq_vector}, 32'd21);

    // R8: clearing all ones leaves message number and sources
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d);
    chk("R8 flags cleared", {25'd0, d[6:0]}, 32'd0);
    chk("R8 message number kept", {27'd0, d[31:27]}, 32'd21);
    rd(2'd2, d);
    chk("R8 sources kept", d, 32'h0404_0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule